// File: doc/BRIEF.md
# GPIO Edge Interrupt and Event Generator

This block watches a bank of already-synchronized GPIO pin values and turns selected transitions into pulses. For every pin, software picks whether a rising transition, a falling transition, both, or neither should count. When a selected transition is seen, the block emits a one-clock pulse on that pin's interrupt output and on its DMA synchronization event output. A single bank-wide enable bit gates every pulse. Detection does not depend on the pin direction, so a pin that software drives as an output can trigger its own interrupt. No halt or debug state stops the detector.

The rising-edge and falling-edge enables cannot be written directly. Each set of enables is changed only through a pair of aliases on the shared 32-bit register bus. Writing 1 to a bit of the "set" alias turns that enable on. Writing 1 to a bit of the "clear" alias turns it off. Writing 0 leaves the bit alone. Reading either alias of a pair returns the current enable state. The interrupt and DMA controllers, the pad logic and the input synchronizers are outside this block.

Top module: `gpio_edge_event_gen`

## Requirements
- R1: After a synchronous reset, all rising enables, all falling enables and the bank enable are 0, no interrupt or event pulse is produced, and reads of 0x08, 0x24 and 0x2C return 0.
- R2: A write to 0x24 sets the rising enable of every pin whose data bit (bit n for pin n) is 1. A write to 0x28 clears the rising enable of every such pin. Pins whose data bit is 0 keep their enable.
- R3: A write to 0x2C sets falling enables and a write to 0x30 clears falling enables, with the same bit-per-pin and write-1-only rule as R2.
- R4: A read of 0x24 or of 0x28 returns the rising enables in bits 15..0. A read of 0x2C or of 0x30 returns the falling enables in bits 15..0. Bits 31..16 read as 0.
- R5: Bit 0 of a write to 0x08 loads the bank enable. A read of 0x08 returns the bank enable in bit 0, and bits 31..1 read as 0.
- R6: If a pin's sampled value goes from 0 to 1 while its rising enable and the bank enable are 1, bit n of both irq_pulse and dma_evt_pulse is 1 for exactly one clock. That clock is the one that follows the clock edge at which the new value is first sampled.
- R7: If a pin's sampled value goes from 1 to 0 while its falling enable and the bank enable are 1, it gives the same one-clock pulse on both outputs with the same timing as R6.
- R8: With both enables set, every change of the pin gives exactly one pulse. With neither enable set, or with only the enable of the opposite direction set, a change gives no pulse.
- R9: While the bank enable is 0, no pin produces a pulse on either output, whatever its trigger enables and transitions are.
- R10: Pins are independent. Several pins that change in the same clock each pulse in the same cycle according to their own enables.
- R11: If an enable write and a pin transition on the same pin fall in the same clock, the enable value from before the write decides whether that transition pulses.
- R12: Writes to addresses other than 0x08, 0x24, 0x28, 0x2C and 0x30 change no state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one write per clock |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_sync | input | 16 | Synchronized pin values |
| irq_pulse | output | 16 | Per-pin interrupt pulse |
| dma_evt_pulse | output | 16 | Per-pin DMA synchronization event pulse |

## Verification
An enable-alias write and a transition on the same pin can fall in the same clock. The bench provokes this in two ways: a clear-rising write issued together with a rising edge on an enabled pin, and a set-rising write issued together with a rising edge on a disabled pin. In both cases the outcome is judged against the enable state held before the write. The first case must give a pulse and the second must not. The following transition of that pin then confirms that the write itself took effect.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Register byte offsets on the shared bus
    localparam int unsigned OFS_BANK_EN   = 32'h08;
    localparam int unsigned OFS_RISE_SET  = 32'h24;
    localparam int unsigned OFS_RISE_CLR  = 32'h28;
    localparam int unsigned OFS_FALL_SET  = 32'h2C;
    localparam int unsigned OFS_FALL_CLR  = 32'h30;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK,
        SEL_RISE_SET,
        SEL_RISE_CLR,
        SEL_FALL_SET,
        SEL_FALL_CLR
    } reg_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_flags_t;

    function automatic reg_sel_e decode_offset(input int unsigned ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_BANK_EN:  sel = SEL_BANK;
            OFS_RISE_SET: sel = SEL_RISE_SET;
            OFS_RISE_CLR: sel = SEL_RISE_CLR;
            OFS_FALL_SET: sel = SEL_FALL_SET;
            OFS_FALL_CLR: sel = SEL_FALL_CLR;
            default:      sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    function automatic logic is_rise_alias(input reg_sel_e sel);
        return (sel == SEL_RISE_SET) || (sel == SEL_RISE_CLR);
    endfunction

    function automatic logic is_fall_alias(input reg_sel_e sel);
        return (sel == SEL_FALL_SET) || (sel == SEL_FALL_CLR);
    endfunction

endpackage

// File: rtl/gpio_trig_regs.sv
module gpio_trig_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [NUM_PINS-1:0] rise_en,
    output logic [NUM_PINS-1:0] fall_en,
    output logic                bank_en
);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wmask;
    logic                unused_wdata;

    assign sel          = decode_offset(32'(addr));
    assign wmask        = wdata[NUM_PINS-1:0];
    assign unused_wdata = ^wdata[DATA_W-1:NUM_PINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en <= '0;
            fall_en <= '0;
            bank_en <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_BANK:     bank_en <= wdata[0];
                SEL_RISE_SET: rise_en <= rise_en | wmask;
                SEL_RISE_CLR: rise_en <= rise_en & ~wmask;
                SEL_FALL_SET: fall_en <= fall_en | wmask;
                SEL_FALL_CLR: fall_en <= fall_en & ~wmask;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (sel == SEL_BANK)
            rdata = DATA_W'(bank_en);
        else if (is_rise_alias(sel))
            rdata = DATA_W'(rise_en);
        else if (is_fall_alias(sel))
            rdata = DATA_W'(fall_en);
    end

    // R2: a set write turns on exactly the masked bits, the rest hold
    a_r2_rise_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_RISE_SET) |=>
            (rise_en == ($past(rise_en) | $past(wmask))));

    // R2: a clear write turns off exactly the masked bits
    a_r2_rise_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_RISE_CLR) |=>
            (rise_en == ($past(rise_en) & ~$past(wmask))));

    // R3: falling aliases behave the same way
    a_r3_fall_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_FALL_SET) |=>
            (fall_en == ($past(fall_en) | $past(wmask))));

    a_r3_fall_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_FALL_CLR) |=>
            (fall_en == ($past(fall_en) & ~$past(wmask))));

    // R12: unmapped writes leave all state alone
    a_r12_unmapped_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || sel == SEL_NONE) |=>
            ($stable(rise_en) && $stable(fall_en) && $stable(bank_en)));

    // R5: only bit 0 of the bank register can ever read as 1
    a_r5_bank_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_BANK) |-> (rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] rise_seen,
    output logic [NUM_PINS-1:0] fall_seen
);

    logic [NUM_PINS-1:0] prev_pin;
    edge_flags_t         flags [NUM_PINS];

    // The previous-value register tracks the pins during reset too, so
    // the first cycle after release never sees a stale value.
    always_ff @(posedge clk) begin
        if (rst) prev_pin <= pin_sync;
        else     prev_pin <= pin_sync;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign flags[g].rise = pin_sync[g] & ~prev_pin[g];
        assign flags[g].fall = ~pin_sync[g] & prev_pin[g];
        assign rise_seen[g]  = flags[g].rise;
        assign fall_seen[g]  = flags[g].fall;
    end

    // R8: a transition is seen only where the pin differs from one clock ago
    a_r8_seen_needs_change: assert property (@(posedge clk) disable iff (rst)
        ((rise_seen | fall_seen) & ~(pin_sync ^ $past(pin_sync))) == '0);

endmodule

// File: rtl/gpio_pulse_gen.sv
module gpio_pulse_gen #(
    parameter int unsigned NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] rise_seen,
    input  logic [NUM_PINS-1:0] fall_seen,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic                bank_en,
    output logic [NUM_PINS-1:0] irq_q,
    output logic [NUM_PINS-1:0] evt_q
);

    logic [NUM_PINS-1:0] qualified;
    logic [NUM_PINS-1:0] hit;

    assign qualified = (rise_seen & rise_en) | (fall_seen & fall_en);
    assign hit       = bank_en ? qualified : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            evt_q <= '0;
        end else begin
            irq_q <= hit;
            evt_q <= hit;
        end
    end

    // R9: any pulse needs the bank enable one clock earlier
    a_r9_bank_gate: assert property (@(posedge clk) disable iff (rst)
        (|irq_q || |evt_q) |-> $past(bank_en));

    // R6: interrupt and DMA event always pulse together
    a_r6_irq_evt_match: assert property (@(posedge clk) disable iff (rst)
        irq_q == evt_q);

    // R8: a pulse needs some trigger enable on that pin
    a_r8_enable_needed: assert property (@(posedge clk) disable iff (rst)
        (irq_q & ~($past(rise_en) | $past(fall_en))) == '0);

endmodule

// File: rtl/gpio_edge_event_gen.sv
module gpio_edge_event_gen
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NUM_PINS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] irq_pulse,
    output logic [NUM_PINS-1:0] dma_evt_pulse
);

    logic [NUM_PINS-1:0] rise_en;
    logic [NUM_PINS-1:0] fall_en;
    logic                bank_en;
    logic [NUM_PINS-1:0] rise_seen;
    logic [NUM_PINS-1:0] fall_seen;

    gpio_trig_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .bank_en (bank_en)
    );

    gpio_edge_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .clk       (clk),
        .rst       (rst),
        .pin_sync  (pin_sync),
        .rise_seen (rise_seen),
        .fall_seen (fall_seen)
    );

    gpio_pulse_gen #(
        .NUM_PINS (NUM_PINS)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .rise_seen (rise_seen),
        .fall_seen (fall_seen),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .bank_en   (bank_en),
        .irq_q     (irq_pulse),
        .evt_q     (dma_evt_pulse)
    );

    // R6/R7: a pulse only follows a change between the two prior samples
    a_r6_pulse_follows_change: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse & ~($past(pin_sync) ^ $past(pin_sync, 2))) == '0);

    // R7: a falling pulse needs the falling enable, a rising one the rising enable
    a_r7_direction_enable: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse & ~(($past(pin_sync) & $past(rise_en)) |
                       (~$past(pin_sync) & $past(fall_en)))) == '0);

endmodule

// File: tb/tb_gpio_edge_event_gen.sv
`timescale 1ns/1ps
module tb_gpio_edge_event_gen;

    localparam int unsigned NP = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pin_sync = '0;
    logic [NP-1:0] irq_pulse;
    logic [NP-1:0] dma_evt_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench mirror of the programmed state
    logic [NP-1:0] m_rise = '0;
    logic [NP-1:0] m_fall = '0;
    logic          m_bank = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_event_gen dut (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pin_sync      (pin_sync),
        .irq_pulse     (irq_pulse),
        .dma_evt_pulse (dma_evt_pulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] expect_pulse(input logic [NP-1:0] old_p,
                                                   input logic [NP-1:0] new_p);
        if (!m_bank) return '0;
        return (new_p & ~old_p & m_rise) | (~new_p & old_p & m_fall);
    endfunction

    function automatic void mirror_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h08: m_bank = d[0];
            8'h24: m_rise = m_rise | d[NP-1:0];
            8'h28: m_rise = m_rise & ~d[NP-1:0];
            8'h2C: m_fall = m_fall | d[NP-1:0];
            8'h30: m_fall = m_fall & ~d[NP-1:0];
            default: ;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
        mirror_write(a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    // drive new pins, check the pulse cycle and the quiet cycle after it
    task automatic pins(input string tag, input logic [NP-1:0] nv);
        logic [NP-1:0] e;
        e = expect_pulse(pin_sync, nv);
        pin_sync = nv;
        step();
        chk({tag, " irq"}, 32'(irq_pulse), 32'(e));
        chk({tag, " evt"}, 32'(dma_evt_pulse), 32'(e));
        step();
        chk({tag, " idle"}, 32'(irq_pulse | dma_evt_pulse), 32'h0);
    endtask

    task automatic t_reset();
        pin_sync = 16'hA5A5;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 irq after reset", 32'(irq_pulse), 32'h0);
        chk("R1 evt after reset", 32'(dma_evt_pulse), 32'h0);
        rd_chk("R1 bank read", 8'h08, 32'h0);
        rd_chk("R1 rise read", 8'h24, 32'h0);
        rd_chk("R1 fall read", 8'h2C, 32'h0);
        pin_sync = 16'h0000;
        step(); step();
        chk("R1 no pulse while disabled", 32'(irq_pulse), 32'h0);
    endtask

    task automatic t_trig_regs();
        wr(8'h24, 32'hFFFF_00F0);
        rd_chk("R4 rise via set alias", 8'h24, 32'h0000_00F0);
        rd_chk("R4 rise via clr alias", 8'h28, 32'h0000_00F0);
        wr(8'h24, 32'h0000_0003);
        rd_chk("R2 set keeps zeros", 8'h24, 32'h0000_00F3);
        wr(8'h28, 32'h0000_0010);
        rd_chk("R2 clear one bit", 8'h24, 32'h0000_00E3);
        wr(8'h28, 32'h0000_0000);
        rd_chk("R2 clear zero no effect", 8'h28, 32'h0000_00E3);
        wr(8'h2C, 32'h0000_0F00);
        wr(8'h30, 32'h0000_0300);
        rd_chk("R3 fall via set alias", 8'h2C, 32'h0000_0C00);
        rd_chk("R3 fall via clr alias", 8'h30, 32'h0000_0C00);
        rd_chk("R3 rise unaffected", 8'h24, 32'h0000_00E3);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R12 rise after unmapped", 8'h24, 32'h0000_00E3);
        rd_chk("R12 fall after unmapped", 8'h2C, 32'h0000_0C00);
        rd_chk("R12 bank after unmapped", 8'h08, 32'h0);
        rd_chk("R12 unmapped read", 8'h34, 32'h0);
        wr(8'h28, 32'h0000_FFFF);
        wr(8'h30, 32'h0000_FFFF);
        rd_chk("R2 all cleared", 8'h28, 32'h0);
    endtask

    task automatic t_bank();
        wr(8'h24, 32'h0000_0001);
        wr(8'h2C, 32'h0000_0001);
        pins("R9 rise with bank off", 16'h0001);
        pins("R9 fall with bank off", 16'h0000);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R5 bank readback", 8'h08, 32'h0000_0001);
        wr(8'h30, 32'h0000_0001);
    endtask

    task automatic t_rise();
        pins("R6 rise pin0", 16'h0001);
        pins("R6 fall pin0 not enabled", 16'h0000);
    endtask

    task automatic t_fall();
        wr(8'h2C, 32'h0000_0002);
        pins("R7 rise pin1 not enabled", 16'h0002);
        pins("R7 fall pin1", 16'h0000);
    endtask

    task automatic t_both();
        wr(8'h24, 32'h0000_0004);
        wr(8'h2C, 32'h0000_0004);
        pins("R8 both up", 16'h0004);
        pins("R8 both down", 16'h0000);
        pins("R8 both up again", 16'h0004);
        pins("R8 no enable pin3", 16'h000C);
        pins("R8 no enable pin3 down", 16'h0004);
        pins("R8 both down again", 16'h0000);
    endtask

    task automatic t_multi();
        pins("R10 setup", 16'h0002);
        pins("R10 mixed pins", 16'h0005);
        pins("R10 all down", 16'h0000);
        wr(8'h08, 32'h0);
        pins("R9 multi with bank off", 16'h0005);
        wr(8'h08, 32'h1);
        pins("R10 down with bank on", 16'h0000);
    endtask

    task automatic t_same_cycle();
        logic [NP-1:0] e;
        wr(8'h24, 32'h0000_0010);
        // clear-rising and rising edge in the same clock: old enable wins
        e = expect_pulse(pin_sync, 16'h0010);
        bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0000_0010;
        pin_sync = 16'h0010;
        step();
        bus_wr = 1'b0;
        mirror_write(8'h28, 32'h0000_0010);
        chk("R11 clear with edge pulses", 32'(irq_pulse), 32'(e));
        step();
        pins("R11 low", 16'h0000);
        pins("R11 clear took effect", 16'h0010);
        pins("R11 low again", 16'h0000);
        // set-rising and rising edge in the same clock: no pulse
        e = expect_pulse(pin_sync, 16'h0010);
        bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = 32'h0000_0010;
        pin_sync = 16'h0010;
        step();
        bus_wr = 1'b0;
        mirror_write(8'h24, 32'h0000_0010);
        chk("R11 set with edge silent", 32'(irq_pulse), 32'(e));
        step();
        pins("R11 low before retry", 16'h0000);
        pins("R11 set took effect", 16'h0010);
    endtask

    initial begin
        t_reset();
        t_trig_regs();
        t_bank();
        t_rise();
        t_fall();
        t_both();
        t_multi();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule